// File: doc/BRIEF.md
# Translation Fault Exception Entry

This unit performs exception entry for address-translation faults in a 32-bit core. Bits are numbered big-endian: architectural bit 0 is the most significant bit, at vector index 31. Three fault sources feed it: an instruction-side translation error, a data-side translation miss, and a data-side translation error. The unit classifies the data-side error itself from the access kind and the page attributes. It picks one fault per cycle. On the next clock edge it loads the saved-PC register (SRR0) and the saved-status register (SRR1), writes the rewritten machine state word, and pulses a redirect with the handler fetch address.

The core presents its current machine state on `msr_i`. It also presents the addresses of the instructions that own the instruction-side fault and the data access. The register outputs hold their values between entries, so they act as the architectural SRR0, SRR1 and MSR after an entry. The core must take `msr_o` as its new machine state when `redirect_o` pulses.

Top module: `fault_entry`

## Requirements
- R1: On entry, `srr0_o` holds `ipc_i` for an instruction-side fault and `dpc_i` for a data-side fault, sampled in the request cycle.
- R2: On entry, SRR1 architectural bits 0..15 (vector bits 31..16) read 0, and bits 16..31 (vector bits 15..0) equal the same bits of `msr_i`. The recoverable bit, architectural 30 (vector bit 1), therefore follows MSR bit 30 in both directions.
- R3: On entry, `msr_o` keeps IP (architectural 25, vector bit 6) and ME (architectural 19, vector bit 12). LE (architectural 31, vector bit 0) takes ILE (architectural 15, vector bit 16). Every other bit is 0.
- R4: The redirect address is the base ORed with the vector offset. The base is 0xFFF00000 when IP=1 and 0x00000000 when IP=0. The offsets are 0x1300 for the instruction error, 0x1200 for the data miss and 0x1400 for the data error.
- R5: A data miss (`dmiss_i`) is taken only when data relocation, MSR architectural bit 27 (vector bit 4), is 1. Otherwise it has no effect.
- R6: A data error is raised for an access when any of these holds: the segment valid bit is 0, the page valid bit is 0, `prot_viol_i` is 1, or the access writes and `change_i` is 0. The `acc_op_i` codes are 0 none, 1 load, 2 store, 3 icbi, 4 dcbz, 5 dcbst, 6 dcbf, 7 dcbi. Only store (2) and dcbz (4) are writes.
- R7: With `acc_op_i` = 0, the attribute inputs raise no fault.
- R8: The priority order is instruction error, then data miss, then data error, and only one entry is made per cycle. `cause_o` encodes 1 for the instruction error, 2 for the data miss and 3 for the data error.
- R9: A protection violation together with a cleared change bit on a valid translation gives a single entry with cause 3 and a one-cycle redirect.
- R10: All outputs are registered and read 0 after reset. `redirect_o` is high for exactly one cycle per entry, and the other outputs hold their values when no entry is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| itlb_err_i | input | 1 | Instruction-side translation error request |
| dmiss_i | input | 1 | Data-side translation miss |
| acc_op_i | input | 3 | Data access kind (0 = none) |
| seg_valid_i | input | 1 | Segment valid bit of the data page |
| page_valid_i | input | 1 | Page valid bit of the data page |
| prot_viol_i | input | 1 | Data access violates protection |
| change_i | input | 1 | Change bit of the data page |
| ipc_i | input | 32 | Address of the instruction that owns the instruction-side fault |
| dpc_i | input | 32 | Address of the instruction that issues the data access |
| msr_i | input | 32 | Current machine state |
| redirect_o | output | 1 | One-cycle redirect pulse |
| redirect_pc_o | output | 32 | Handler fetch address |
| cause_o | output | 2 | Fault taken on the last entry |
| srr0_o | output | 32 | Saved PC |
| srr1_o | output | 32 | Saved status |
| msr_o | output | 32 | Machine state after entry |

## Verification
The bench targets the write-permission corner cases. A store or dcbz to a clean page must fault, and a load or cache flush to the same page must not; a classifier that ignored the access kind would fault on reads or miss the dcbz. Each of the three faults is raised together with the others to pin down the priority, since a wrong arbiter would report cause 2 or 3 with the data PC. The bench also sets a data miss with relocation off, and sets bad attributes with no access, to check that neither causes a spurious entry. It walks machine-state patterns with IP, ILE and RI set and cleared: a design with a bit-order mistake would load SRR1 from the wrong half, leave stale bits set in the new state, or fetch from the low base.

// File: rtl/fault_entry_pkg.sv
package fault_entry_pkg;
  localparam int XLEN = 32;
  localparam int HALF = XLEN / 2;

  // vector index of big-endian architectural bit n is XLEN-1-n
  localparam int MSR_ILE = XLEN - 1 - 15;
  localparam int MSR_ME  = XLEN - 1 - 19;
  localparam int MSR_IP  = XLEN - 1 - 25;
  localparam int MSR_DR  = XLEN - 1 - 27;
  localparam int MSR_RI  = XLEN - 1 - 30;
  localparam int MSR_LE  = XLEN - 1 - 31;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_ICBI  = 3'd3,
    OP_DCBZ  = 3'd4,
    OP_DCBST = 3'd5,
    OP_DCBF  = 3'd6,
    OP_DCBI  = 3'd7
  } acc_op_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_IERR = 2'd1,
    CAUSE_DMISS = 2'd2,
    CAUSE_DERR = 2'd3
  } cause_e;
endpackage

// File: rtl/fault_classify.sv
module fault_classify
  import fault_entry_pkg::*;
(
  input  logic [2:0] acc_op_i,
  input  logic       seg_valid_i,
  input  logic       page_valid_i,
  input  logic       prot_viol_i,
  input  logic       change_i,
  input  logic       dmiss_i,
  input  logic       dr_en_i,
  output logic       dmiss_o,
  output logic       derr_o
);
  acc_op_e op;
  logic    is_write;
  logic    bad_xlat;

  assign op       = acc_op_e'(acc_op_i);
  assign is_write = (op == OP_STORE) || (op == OP_DCBZ);
  assign bad_xlat = !seg_valid_i || !page_valid_i;

  assign dmiss_o = dmiss_i && dr_en_i;
  // protection and clean-page write collapse into one error
  assign derr_o  = (op != OP_NONE) &&
                   (bad_xlat || prot_viol_i || (is_write && !change_i));
endmodule

// File: rtl/fault_arbiter.sv
module fault_arbiter
  import fault_entry_pkg::*;
(
  input  logic            ierr_i,
  input  logic            dmiss_i,
  input  logic            derr_i,
  input  logic [XLEN-1:0] ipc_i,
  input  logic [XLEN-1:0] dpc_i,
  output logic            take_o,
  output cause_e          cause_o,
  output logic [XLEN-1:0] epc_o
);
  always_comb begin
    take_o  = 1'b1;
    cause_o = CAUSE_NONE;
    epc_o   = dpc_i;
    if (ierr_i) begin
      cause_o = CAUSE_IERR;
      epc_o   = ipc_i;
    end else if (dmiss_i) begin
      cause_o = CAUSE_DMISS;
    end else if (derr_i) begin
      cause_o = CAUSE_DERR;
    end else begin
      take_o = 1'b0;
    end
  end
endmodule

// File: rtl/fault_vector.sv
module fault_vector
  import fault_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] LO_BASE   = 32'h0000_0000,
  parameter logic [XLEN-1:0] HI_BASE   = 32'hFFF0_0000,
  parameter logic [XLEN-1:0] OFF_IERR  = 32'h0000_1300,
  parameter logic [XLEN-1:0] OFF_DMISS = 32'h0000_1200,
  parameter logic [XLEN-1:0] OFF_DERR  = 32'h0000_1400
) (
  input  cause_e          cause_i,
  input  logic            ip_i,
  output logic [XLEN-1:0] target_o
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] off;

  assign base = ip_i ? HI_BASE : LO_BASE;

  always_comb begin
    unique case (cause_i)
      CAUSE_IERR:  off = OFF_IERR;
      CAUSE_DMISS: off = OFF_DMISS;
      CAUSE_DERR:  off = OFF_DERR;
      default:     off = '0;
    endcase
  end

  assign target_o = base | off;
endmodule

// File: rtl/fault_state.sv
module fault_state
  import fault_entry_pkg::*;
(
  input  logic [XLEN-1:0] msr_i,
  output logic [XLEN-1:0] srr1_o,
  output logic [XLEN-1:0] msr_o
);
  localparam logic [XLEN-1:0] KEEP = (XLEN'(1) << MSR_IP) | (XLEN'(1) << MSR_ME);

  // architectural bits 0..15 cleared, 16..31 copied
  for (genvar b = 0; b < XLEN; b++) begin : g_srr1
    if (b >= HALF) begin : g_clr
      assign srr1_o[b] = 1'b0;
    end else begin : g_cpy
      assign srr1_o[b] = msr_i[b];
    end
  end

  always_comb begin
    msr_o         = msr_i & KEEP;
    msr_o[MSR_LE] = msr_i[MSR_ILE];
  end
endmodule

// File: rtl/fault_entry.sv
module fault_entry
  import fault_entry_pkg::*;
#(
  parameter logic [31:0] HI_BASE = 32'hFFF0_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        itlb_err_i,
  input  logic        dmiss_i,
  input  logic [2:0]  acc_op_i,
  input  logic        seg_valid_i,
  input  logic        page_valid_i,
  input  logic        prot_viol_i,
  input  logic        change_i,
  input  logic [31:0] ipc_i,
  input  logic [31:0] dpc_i,
  input  logic [31:0] msr_i,
  output logic        redirect_o,
  output logic [31:0] redirect_pc_o,
  output logic [1:0]  cause_o,
  output logic [31:0] srr0_o,
  output logic [31:0] srr1_o,
  output logic [31:0] msr_o
);
  logic            dmiss_q;
  logic            derr;
  logic            take;
  cause_e          cause_n;
  logic [XLEN-1:0] epc;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] srr1_n;
  logic [XLEN-1:0] msr_n;

  fault_classify u_cls (
    .acc_op_i     (acc_op_i),
    .seg_valid_i  (seg_valid_i),
    .page_valid_i (page_valid_i),
    .prot_viol_i  (prot_viol_i),
    .change_i     (change_i),
    .dmiss_i      (dmiss_i),
    .dr_en_i      (msr_i[MSR_DR]),
    .dmiss_o      (dmiss_q),
    .derr_o       (derr)
  );

  fault_arbiter u_arb (
    .ierr_i  (itlb_err_i),
    .dmiss_i (dmiss_q),
    .derr_i  (derr),
    .ipc_i   (ipc_i),
    .dpc_i   (dpc_i),
    .take_o  (take),
    .cause_o (cause_n),
    .epc_o   (epc)
  );

  fault_vector #(.HI_BASE(HI_BASE)) u_vec (
    .cause_i  (cause_n),
    .ip_i     (msr_i[MSR_IP]),
    .target_o (target)
  );

  fault_state u_st (
    .msr_i  (msr_i),
    .srr1_o (srr1_n),
    .msr_o  (msr_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
      cause_o       <= '0;
      srr0_o        <= '0;
      srr1_o        <= '0;
      msr_o         <= '0;
    end else begin
      redirect_o <= take;
      if (take) begin
        redirect_pc_o <= target;
        cause_o       <= cause_n;
        srr0_o        <= epc;
        srr1_o        <= srr1_n;
        msr_o         <= msr_n;
      end
    end
  end
endmodule

// File: rtl/fault_entry_chk.sv
module fault_entry_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        itlb_err_i,
  input logic        dmiss_i,
  input logic [2:0]  acc_op_i,
  input logic [31:0] ipc_i,
  input logic [31:0] msr_i,
  input logic        redirect_o,
  input logic [31:0] redirect_pc_o,
  input logic [1:0]  cause_o,
  input logic [31:0] srr0_o,
  input logic [31:0] srr1_o,
  input logic [31:0] msr_o
);
  // R8
  ierr_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    itlb_err_i |=> redirect_o && cause_o == 2'd1 && srr0_o == $past(ipc_i));

  // R2
  srr1_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> srr1_o[31:16] == 16'h0);

  // R3
  msr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (msr_o & 32'hFFFF_EFBE) == 32'h0);

  // R4
  vector_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> redirect_pc_o[7:0] == 8'h0 && redirect_pc_o[19:15] == 5'h0);

  // R7
  idle_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!itlb_err_i && !dmiss_i && acc_op_i == 3'd0) |=> !redirect_o);

  // R5
  dmiss_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!itlb_err_i && dmiss_i && !msr_i[4] && acc_op_i == 3'd0) |=> !redirect_o);

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_o |-> $stable(srr0_o) && $stable(srr1_o) && $stable(msr_o));
endmodule

bind fault_entry fault_entry_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .itlb_err_i    (itlb_err_i),
  .dmiss_i       (dmiss_i),
  .acc_op_i      (acc_op_i),
  .ipc_i         (ipc_i),
  .msr_i         (msr_i),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .cause_o       (cause_o),
  .srr0_o        (srr0_o),
  .srr1_o        (srr1_o),
  .msr_o         (msr_o)
);

// File: tb/sim_fault_entry.sv
module sim_fault_entry;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        itlb_err_i, dmiss_i, seg_valid_i, page_valid_i, prot_viol_i, change_i;
  logic [2:0]  acc_op_i;
  logic [31:0] ipc_i, dpc_i, msr_i;
  logic        redirect_o;
  logic [31:0] redirect_pc_o, srr0_o, srr1_o, msr_o;
  logic [1:0]  cause_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fault_entry u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] e_srr1(logic [31:0] m);
    return {16'h0, m[15:0]};
  endfunction

  function automatic logic [31:0] e_msr(logic [31:0] m);
    logic [31:0] r = '0;
    r[6] = m[6]; r[12] = m[12]; r[0] = m[16];
    return r;
  endfunction

  function automatic logic [31:0] e_base(logic [31:0] m);
    return m[6] ? 32'hFFF0_0000 : 32'h0;
  endfunction

  task automatic idle();
    itlb_err_i = 0; dmiss_i = 0; acc_op_i = 3'd0;
    seg_valid_i = 1; page_valid_i = 1; prot_viol_i = 0; change_i = 1;
  endtask

  // inputs set at negedge; one posedge later outputs are checked at next negedge
  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic expect_entry(string req, logic [1:0] c, logic [31:0] pc,
                              logic [31:0] m, logic [31:0] off);
    step();
    chk({req, " redirect"}, {31'h0, redirect_o}, 32'h1);
    chk({req, " cause"}, {30'h0, cause_o}, {30'h0, c});
    chk({req, " srr0"}, srr0_o, pc);
    chk({req, " srr1"}, srr1_o, e_srr1(m));
    chk({req, " msr"}, msr_o, e_msr(m));
    chk({req, " target"}, redirect_pc_o, e_base(m) | off);
    idle();
    step();
    chk({req, " R10 pulse end"}, {31'h0, redirect_o}, 32'h0);
  endtask

  task automatic expect_none(string req);
    logic [31:0] s0 = srr0_o;
    step();
    chk({req, " no redirect"}, {31'h0, redirect_o}, 32'h0);
    chk({req, " srr0 held"}, srr0_o, s0);
    idle();
    step();
  endtask

  task automatic t_reset();
    chk("R10 reset redirect", {31'h0, redirect_o}, 0);
    chk("R10 reset srr0", srr0_o, 0);
    chk("R10 reset srr1", srr1_o, 0);
    chk("R10 reset msr", msr_o, 0);
    chk("R10 reset pc", redirect_pc_o, 0);
  endtask

  task automatic t_ierr();
    // R1 R3 R4 low base
    msr_i = 32'h0001_B032; ipc_i = 32'h0000_4A10; dpc_i = 32'h1111_0000;
    itlb_err_i = 1;
    expect_entry("R1 R4 ierr low", 2'd1, 32'h0000_4A10, 32'h0001_B032, 32'h1300);
    // R4 high base, R2 RI=0
    msr_i = 32'hFFFE_FFFD & ~32'h0000_0002 | 32'h40; ipc_i = 32'h8000_0004;
    itlb_err_i = 1;
    expect_entry("R2 R3 R4 ierr high", 2'd1, 32'h8000_0004, msr_i, 32'h1300);
  endtask

  task automatic t_dmiss();
    msr_i = 32'h0000_1052; dpc_i = 32'h0000_2220; dmiss_i = 1;
    expect_entry("R5 dmiss dr on", 2'd2, 32'h0000_2220, 32'h0000_1052, 32'h1200);
    msr_i = 32'h0000_1042; dmiss_i = 1;
    expect_none("R5 dmiss dr off");
  endtask

  task automatic t_derr();
    msr_i = 32'h0001_0002; dpc_i = 32'h0000_3000;
    acc_op_i = 3'd1; page_valid_i = 0;
    expect_entry("R6 load page invalid", 2'd3, 32'h0000_3000, msr_i, 32'h1400);
    acc_op_i = 3'd3; seg_valid_i = 0; dpc_i = 32'h0000_3004;
    expect_entry("R6 icbi seg invalid", 2'd3, 32'h0000_3004, msr_i, 32'h1400);
    acc_op_i = 3'd7; prot_viol_i = 1; dpc_i = 32'h0000_3008;
    expect_entry("R6 dcbi prot", 2'd3, 32'h0000_3008, msr_i, 32'h1400);
    acc_op_i = 3'd2; change_i = 0; dpc_i = 32'h0000_300C;
    expect_entry("R6 store clean", 2'd3, 32'h0000_300C, msr_i, 32'h1400);
    acc_op_i = 3'd4; change_i = 0; dpc_i = 32'h0000_3010;
    expect_entry("R6 dcbz clean", 2'd3, 32'h0000_3010, msr_i, 32'h1400);
    acc_op_i = 3'd1; change_i = 0;
    expect_none("R6 load clean ok");
    acc_op_i = 3'd6; change_i = 0;
    expect_none("R6 dcbf clean ok");
    acc_op_i = 3'd0; page_valid_i = 0; seg_valid_i = 0; prot_viol_i = 1; change_i = 0;
    expect_none("R7 no access");
  endtask

  task automatic t_combo();
    msr_i = 32'h0000_0040; dpc_i = 32'h0000_5000;
    acc_op_i = 3'd2; prot_viol_i = 1; change_i = 0;
    expect_entry("R9 prot+clean", 2'd3, 32'h0000_5000, msr_i, 32'h1400);
  endtask

  task automatic t_prio();
    msr_i = 32'h0000_0012; ipc_i = 32'h0000_6000; dpc_i = 32'h0000_7000;
    itlb_err_i = 1; dmiss_i = 1; acc_op_i = 3'd1; page_valid_i = 0;
    expect_entry("R8 all three", 2'd1, 32'h0000_6000, msr_i, 32'h1300);
    dmiss_i = 1; acc_op_i = 3'd2; prot_viol_i = 1;
    expect_entry("R8 miss over err", 2'd2, 32'h0000_7000, msr_i, 32'h1200);
  endtask

  initial begin
    idle(); ipc_i = 0; dpc_i = 0; msr_i = 0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    step();
    t_reset();
    t_ierr();
    t_dmiss();
    t_derr();
    t_combo();
    t_prio();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule